// File: doc/BRIEF.md
# UART Sleep Mode Controller

This block decides, cycle by cycle, whether a UART may switch off its oscillator driver. It runs on an always-on clock and watches the sleep-enable control bit, the serial receive and clear-to-send pin levels, a start-bit pulse from the receiver, host strobes for writing transmit data and reading receive data, and status for transmitter idle, receive data available and interrupt pending. It drives an oscillator-enable output and a sleep status bit.

While sleep is enabled and the UART has been quiet long enough, the controller drops the oscillator enable. Any wake source raises it again. Strobes and interrupts do this in the same cycle, through a combinational path that needs no clock edge. Pin level changes do it once they have passed a two-flop synchroniser. After a wake, the controller goes back to sleep by itself once the last character has gone out or been read. It never sleeps while an interrupt is pending or while sleep is disabled.

Top module: `uart_sleep_ctl`

## Requirements
- R1: After reset is released the controller is awake: `osc_en`=1 and `sleep_st`=0.
- R2: While `sleep_en`=0, `osc_en` is 1 in the same cycle, whatever the other inputs are. Clearing `sleep_en` while asleep raises `osc_en` at once and the controller stays awake.
- R3: A 1 on `start_det` or `thr_wr` while asleep raises `osc_en` in the same cycle. The controller is awake from the next clock edge.
- R4: A level change on `rx_pin` while asleep raises `osc_en` after the second clock edge following the change (two-flop synchroniser). `osc_en` stays 1 after the third edge.
- R5: A level change on `cts_pin` behaves as in R4.
- R6: With `sleep_en`=1, `tx_idle`=1, `rx_avail`=0, `irq_pend`=0 and no wake source or read strobe, held for QUIET_CYC consecutive clock edges (default 2), the controller is asleep after edge QUIET_CYC and still awake after edge QUIET_CYC-1.
- R7: While `irq_pend`=1 the controller is never asleep. An interrupt that rises while asleep raises `osc_en` in the same cycle.
- R8: `tx_idle`=0 or `rx_avail`=1 blocks sleep entry indefinitely.
- R9: `sleep_st` is always the inverse of `osc_en`.
- R10: A 1 on `rbr_rd` restarts the quiet count of R6. It does not wake a sleeping controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_en | input | 1 | Sleep permission (control bit 4 of the interrupt-enable register) |
| rx_pin | input | 1 | Serial receive pin level, asynchronous |
| cts_pin | input | 1 | Clear-to-send pin level, asynchronous |
| start_det | input | 1 | Start bit detected pulse |
| thr_wr | input | 1 | Host write to transmit holding strobe |
| rbr_rd | input | 1 | Host read of receive data strobe |
| tx_idle | input | 1 | Transmitter idle, nothing left to send |
| rx_avail | input | 1 | Receive data waiting for the host |
| irq_pend | input | 1 | An interrupt is pending |
| osc_en | output | 1 | Oscillator driver enable |
| sleep_st | output | 1 | Sleep status, 1 while asleep |

## Verification
A wrong state or quiet count shows at `osc_en` within QUIET_CYC+1 edges. The oscillator then drops early or late, or fails to drop at all, and the sweep over every combination of the four gating inputs catches this. A broken synchroniser or previous-value register shows as a pin wake that comes one edge early or late, or never comes. A missing combinational wake term shows as `osc_en` still 0 in the cycle of the strobe.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic {
    PWR_AWAKE  = 1'b0,
    PWR_ASLEEP = 1'b1
  } pwr_state_e;

  localparam int PIN_RX  = 0;
  localparam int PIN_CTS = 1;
  localparam int NUM_PINS = 2;
endpackage

// File: rtl/slp_pin_watch.sv
module slp_pin_watch #(
  parameter int          WIDTH   = 2,
  parameter logic        IDLE_LV = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] chg_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= IDLE_LV;
        sync_q <= IDLE_LV;
        prev_q <= IDLE_LV;
      end else begin
        meta_q <= pins_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign chg_o[g] = sync_q ^ prev_q;
  end
endmodule

// File: rtl/slp_quiet_cnt.sv
module slp_quiet_cnt #(
  parameter int QUIET_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic quiet_i,
  output logic done_o
);
  localparam int CW = (QUIET_CYC < 2) ? 1 : $clog2(QUIET_CYC);
  localparam logic [CW-1:0] LAST = CW'(QUIET_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = quiet_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr_i || !quiet_i) cnt_q <= '0;
    else if (!done_o)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/slp_state.sv
module slp_state
  import slp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wake_i,
  input  logic enter_i,
  output logic asleep_o
);
  pwr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PWR_AWAKE:  if (enter_i && !wake_i) st_d = PWR_ASLEEP;
      PWR_ASLEEP: if (wake_i)             st_d = PWR_AWAKE;
      default:                            st_d = PWR_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PWR_AWAKE;
    else        st_q <= st_d;
  end

  assign asleep_o = (st_q == PWR_ASLEEP);
endmodule

// File: rtl/uart_sleep_ctl.sv
module uart_sleep_ctl
  import slp_pkg::*;
#(
  parameter int QUIET_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_en,
  input  logic rx_pin,
  input  logic cts_pin,
  input  logic start_det,
  input  logic thr_wr,
  input  logic rbr_rd,
  input  logic tx_idle,
  input  logic rx_avail,
  input  logic irq_pend,
  output logic osc_en,
  output logic sleep_st
);
  logic [NUM_PINS-1:0] pins, pin_chg;
  logic wake_req, quiet, enter, asleep;

  assign pins[PIN_RX]  = rx_pin;
  assign pins[PIN_CTS] = cts_pin;

  slp_pin_watch #(.WIDTH(NUM_PINS), .IDLE_LV(1'b1)) u_pins (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .chg_o(pin_chg)
  );

  // Combinational wake: strobes and interrupts reach osc_en without a clock edge.
  assign wake_req = !sleep_en || irq_pend || start_det || thr_wr || (|pin_chg);
  assign quiet    = tx_idle && !rx_avail && !rbr_rd && !wake_req;

  slp_quiet_cnt #(.QUIET_CYC(QUIET_CYC)) u_quiet (
    .clk(clk), .rst_n(rst_n), .clr_i(asleep), .quiet_i(quiet), .done_o(enter)
  );

  slp_state u_state (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_req), .enter_i(enter), .asleep_o(asleep)
  );

  assign osc_en   = !asleep || wake_req;
  assign sleep_st = !osc_en;
endmodule

// File: rtl/uart_sleep_ctl_chk.sv
module uart_sleep_ctl_chk #(
  parameter int QUIET_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic sleep_en,
  input logic start_det,
  input logic thr_wr,
  input logic rbr_rd,
  input logic tx_idle,
  input logic rx_avail,
  input logic irq_pend,
  input logic osc_en,
  input logic sleep_st
);
  localparam int CW = $clog2(QUIET_CYC + 1) + 1;
  localparam logic [CW-1:0] SAT = CW'(QUIET_CYC);

  logic          port_quiet;
  logic [CW-1:0] run_q;

  assign port_quiet = sleep_en && tx_idle && !rx_avail && !irq_pend &&
                      !start_det && !thr_wr && !rbr_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (!port_quiet) run_q <= '0;
    else if (run_q != SAT) run_q <= run_q + 1'b1;
  end

  p_reset_awake_r1: assert property (@(posedge clk) $rose(rst_n) |-> osc_en);
  p_disabled_awake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_en |-> osc_en);
  p_strobe_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || thr_wr) |-> osc_en);
  p_strobe_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || thr_wr) |=> osc_en);
  p_quiet_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> (run_q >= SAT));
  p_irq_awake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> osc_en);
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && (!tx_idle || rx_avail)) |=> osc_en);
  p_status_inverse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_st != osc_en);
endmodule

bind uart_sleep_ctl uart_sleep_ctl_chk #(.QUIET_CYC(QUIET_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .start_det(start_det),
  .thr_wr(thr_wr), .rbr_rd(rbr_rd), .tx_idle(tx_idle), .rx_avail(rx_avail),
  .irq_pend(irq_pend), .osc_en(osc_en), .sleep_st(sleep_st)
);

// File: tb/uart_sleep_ctl_tb.sv
`timescale 1ns/1ps
module uart_sleep_ctl_tb;
  localparam int QC = 2;

  logic clk = 1'b0;
  logic rst_n, sleep_en, rx_pin, cts_pin, start_det, thr_wr, rbr_rd;
  logic tx_idle, rx_avail, irq_pend;
  logic osc_en, sleep_st;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  uart_sleep_ctl #(.QUIET_CYC(QC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .rx_pin(rx_pin),
    .cts_pin(cts_pin), .start_det(start_det), .thr_wr(thr_wr), .rbr_rd(rbr_rd),
    .tx_idle(tx_idle), .rx_avail(rx_avail), .irq_pend(irq_pend),
    .osc_en(osc_en), .sleep_st(sleep_st)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input logic exp_osc, input string tag);
    checks++;
    if (osc_en !== exp_osc) begin
      errors++;
      $display("FAIL %s: osc_en=%b expected %b at %0t", tag, osc_en, exp_osc, $time);
    end
    checks++;
    if (sleep_st !== !exp_osc) begin
      errors++;
      $display("FAIL R9 (%s): sleep_st=%b expected %b", tag, sleep_st, !exp_osc);
    end
  endtask

  task automatic set_idle();
    sleep_en = 1'b1; tx_idle = 1'b1; rx_avail = 1'b0; irq_pend = 1'b0;
    start_det = 1'b0; thr_wr = 1'b0; rbr_rd = 1'b0;
  endtask

  task automatic go_sleep(input string tag);
    set_idle();
    tick(QC + 1);
    chk(1'b0, tag);
  endtask

  task automatic force_awake();
    sleep_en = 1'b0;
    tick(1);
  endtask

  initial begin
    rst_n = 1'b0; sleep_en = 1'b0; rx_pin = 1'b1; cts_pin = 1'b1;
    start_det = 1'b0; thr_wr = 1'b0; rbr_rd = 1'b0;
    tx_idle = 1'b1; rx_avail = 1'b0; irq_pend = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(1'b1, "R1 reset awake");
    tick(5);
    chk(1'b1, "R2 sleep disabled stays awake");

    // Sweep all gating input combinations: sleep_en, tx_idle, rx_avail, irq_pend
    for (int m = 0; m < 16; m++) begin
      logic good;
      force_awake();
      sleep_en = m[0]; tx_idle = m[1]; rx_avail = m[2]; irq_pend = m[3];
      good = m[0] && m[1] && !m[2] && !m[3];
      tick(QC - 1);
      chk(1'b1, "R6 awake before window ends");
      tick(1);
      chk(!good, good ? "R6 enters sleep" : "R2/R7/R8 sleep blocked");
      tick(2);
      chk(!good, good ? "R6 stays asleep" : "R2/R7/R8 still blocked");
    end

    // Strobe wakes: 0 start_det, 1 thr_wr
    for (int s = 0; s < 2; s++) begin
      go_sleep("R6 pre-strobe sleep");
      @(negedge clk);
      if (s == 0) start_det = 1'b1; else thr_wr = 1'b1;
      #1;
      chk(1'b1, "R3 same-cycle wake");
      @(negedge clk);
      start_det = 1'b0; thr_wr = 1'b0;
      #1;
      chk(1'b1, "R3 awake after edge");
      tick(QC - 1);
      chk(1'b1, "R6 awake inside window");
      tick(1);
      chk(1'b0, "R6 re-enters sleep by itself");
    end

    // Pin change wakes: rx fall, cts fall, rx rise, cts rise
    for (int p = 0; p < 4; p++) begin
      go_sleep("R6 pre-pin sleep");
      @(negedge clk);
      if (p % 2 == 0) rx_pin = ~rx_pin; else cts_pin = ~cts_pin;
      #1;
      chk(1'b0, (p % 2 == 0) ? "R4 no instant wake" : "R5 no instant wake");
      tick(1);
      chk(1'b0, (p % 2 == 0) ? "R4 asleep after edge 1" : "R5 asleep after edge 1");
      tick(1);
      chk(1'b1, (p % 2 == 0) ? "R4 wake after edge 2" : "R5 wake after edge 2");
      tick(1);
      chk(1'b1, (p % 2 == 0) ? "R4 awake after edge 3" : "R5 awake after edge 3");
      tick(QC);
      chk(1'b0, "R6 re-entry after pin wake");
    end

    // Interrupt while asleep
    go_sleep("R6 pre-irq sleep");
    @(negedge clk); irq_pend = 1'b1; #1;
    chk(1'b1, "R7 irq wakes same cycle");
    tick(3);
    chk(1'b1, "R7 irq keeps awake");
    @(negedge clk); irq_pend = 1'b0; #1;
    tick(QC);
    chk(1'b0, "R6 sleep after irq cleared");

    // Clearing sleep_en while asleep
    @(negedge clk); sleep_en = 1'b0; #1;
    chk(1'b1, "R2 disable wakes same cycle");
    tick(3);
    chk(1'b1, "R2 disable keeps awake");

    // Read strobe restarts the count and does not wake
    force_awake();
    set_idle();
    tick(1);
    rbr_rd = 1'b1;
    tick(1);
    chk(1'b1, "R10 read restarts count");
    rbr_rd = 1'b0;
    tick(QC - 1);
    chk(1'b1, "R10 awake inside restarted window");
    tick(1);
    chk(1'b0, "R10 sleep after restarted window");
    rbr_rd = 1'b1;
    tick(3);
    chk(1'b0, "R10 read does not wake");
    rbr_rd = 1'b0;

    // Busy transmitter blocks for a long stretch
    force_awake();
    set_idle(); tx_idle = 1'b0;
    tick(20);
    chk(1'b1, "R8 busy transmitter blocks sleep");
    tx_idle = 1'b1;
    tick(QC);
    chk(1'b0, "R8 sleep once transmitter idle");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule